// File: doc/BRIEF.md
# 4B/5B Receive Decoder with Stream Delimiters

This block sits behind a clock and data recovery stage that delivers one code bit per clock at the line symbol rate. While no frame is in progress it searches the serial stream at every bit position for the start-of-stream pair. The first 10-bit match sets the 5-bit group boundary. After that it turns every five received code bits into one 4-bit nibble, which it presents on a receive interface made of a nibble strobe, data valid, receive error and the nibble itself.

Inside a frame the decoder checks each group against the 4B/5B table. A frame ends cleanly on the end-of-stream pair. Several faults are flagged on the nibble output and in three sticky flags: a start pair without its second half, a broken or missing end pair, and code groups that carry no data. A management read strobe clears the flags. Each nibble is qualified by a one-cycle strobe, so downstream logic needs no separate nibble clock.

Top module: `grp5_rx_decoder`

## Requirements
- R1: After reset, rx_stb, rx_dv, rx_er, rxd and stat_flags are all zero, and the decoder is hunting for a frame start.
- R2: The first received bit of a code group is its most significant bit. While hunting, the decoder tests every bit position for 11000 followed immediately by 10001, and takes the group boundary from the first match.
- R3: One clock after the edge that captures the last bit of 10001, rx_stb pulses with rx_dv=1, rx_er=0 and rxd=0101 (the preamble nibble).
- R4: Each later data group is decoded as 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101. It is presented with rx_stb=1, rx_dv=1, rx_er=0 one clock after its last bit is captured, so strobes come every five clocks.
- R5: When rx_stb is low, rx_dv, rx_er and rxd are zero. rx_stb is never high in two consecutive cycles.
- R6: Inside a frame, 01101 followed by 00111 ends the frame with no strobe for either group, and the decoder returns to hunting.
- R7: Inside a frame, a group that is neither data, nor idle 11111, nor an opening 01101 is a codeword error. This includes 11000, 10001, a lone 00111, halt 00100 and every unused code. Such a group gives a strobe with rx_dv=1, rx_er=1, rxd=0000, sets stat_flags[2], and the frame continues.
- R8: Inside a frame, either of the following is an end-delimiter error: 01101 followed by any group other than 00111, or 11111 not preceded by 01101. The offending group gives a strobe with rx_dv=1, rx_er=1, rxd=0000, sets stat_flags[1], and the decoder returns to hunting.
- R9: While hunting, a 10-bit window whose first group is 11000 and whose second is not 10001 gives a strobe with rx_dv=0, rx_er=1, rxd=0000, and sets stat_flags[0].
- R10: A flag is set at the same edge as the strobe that reports its error. A flag stays set until an edge where stat_rd is high. That edge clears every flag except one whose error is reported at that same edge, which stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one code bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Recovered serial code bit |
| stat_rd | input | 1 | Management read strobe; clears the sticky flags |
| rx_stb | output | 1 | One-cycle nibble strobe qualifying the three outputs below |
| rx_dv | output | 1 | Nibble belongs to a frame |
| rx_er | output | 1 | Nibble carries a delimiter or codeword error |
| rxd | output | 4 | Decoded nibble |
| stat_flags | output | 3 | Sticky flags: [0] start delimiter, [1] end delimiter, [2] codeword |

## Verification
The bench uses the default widths: a 5-bit group, a 4-bit nibble and three flags. With only 32 code values, every unused group and every misplaced delimiter can be listed and injected into frames. The five possible alignments of a start pair are reached by prefixing 0 to 4 extra idle bits. A read strobe is timed onto the exact edge of a start-delimiter error to show that a new event wins over the clear.

// File: rtl/grp5_pkg.sv
package grp5_pkg;
    localparam int CODE_W = 5;
    localparam int NIB_W  = 4;
    localparam int PAIR_W = 2 * CODE_W;
    localparam int NFLAG  = 3;
    localparam int CNT_W  = $clog2(CODE_W);

    localparam int F_SSD = 0;
    localparam int F_ESD = 1;
    localparam int F_CW  = 2;

    localparam logic [CODE_W-1:0] G_IDLE = 5'b11111;
    localparam logic [CODE_W-1:0] G_J    = 5'b11000;
    localparam logic [CODE_W-1:0] G_K    = 5'b10001;
    localparam logic [CODE_W-1:0] G_T    = 5'b01101;
    localparam logic [CODE_W-1:0] G_R    = 5'b00111;
    localparam logic [NIB_W-1:0]  N_PRE  = 4'b0101;

    typedef enum logic [2:0] {K_DATA, K_IDLE, K_J, K_K, K_T, K_R, K_BAD} kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [NIB_W-1:0]  nib;
    } dec_t;

    typedef enum logic {S_HUNT, S_FRAME} st_e;

    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  cnt;
        logic              pend_t;
        logic              stb;
        logic              dv;
        logic              er;
        logic [NIB_W-1:0]  rxd;
    } ctl_t;
endpackage

// File: rtl/grp5_shift.sv
module grp5_shift #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         din,
    output logic [W-1:0] win
);
    logic [W-1:0] win_d, win_q;

    always_comb begin
        win_d = {win_q[W-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '1;
        else        win_q <= win_d;
    end

    assign win = win_q;
endmodule

// File: rtl/grp5_lut.sv
module grp5_lut
    import grp5_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output dec_t              dec
);
    always_comb begin
        dec.kind = K_DATA;
        dec.nib  = '0;
        case (code)
            5'b11110: dec.nib = 4'h0;
            5'b01001: dec.nib = 4'h1;
            5'b10100: dec.nib = 4'h2;
            5'b10101: dec.nib = 4'h3;
            5'b01010: dec.nib = 4'h4;
            5'b01011: dec.nib = 4'h5;
            5'b01110: dec.nib = 4'h6;
            5'b01111: dec.nib = 4'h7;
            5'b10010: dec.nib = 4'h8;
            5'b10011: dec.nib = 4'h9;
            5'b10110: dec.nib = 4'hA;
            5'b10111: dec.nib = 4'hB;
            5'b11010: dec.nib = 4'hC;
            5'b11011: dec.nib = 4'hD;
            5'b11100: dec.nib = 4'hE;
            5'b11101: dec.nib = 4'hF;
            G_IDLE:   dec.kind = K_IDLE;
            G_J:      begin dec.kind = K_J; dec.nib = N_PRE; end
            G_K:      begin dec.kind = K_K; dec.nib = N_PRE; end
            G_T:      dec.kind = K_T;
            G_R:      dec.kind = K_R;
            default:  dec.kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/grp5_flags.sv
module grp5_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);
    logic [N-1:0] fl_d, fl_q;

    always_comb begin
        fl_d = (clr ? '0 : fl_q) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags = fl_q;

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((fl_q & $past(fl_q)) == $past(fl_q)));

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set == '0) |=> (fl_q == '0));

    // R10
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((fl_q & $past(set)) == $past(set)));
endmodule

// File: rtl/grp5_rx_decoder.sv
module grp5_rx_decoder
    import grp5_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             stat_rd,
    output logic             rx_stb,
    output logic             rx_dv,
    output logic             rx_er,
    output logic [NIB_W-1:0] rxd,
    output logic [NFLAG-1:0] stat_flags
);
    logic [PAIR_W-1:0] win;
    dec_t              dec;
    ctl_t              d, q;
    logic [NFLAG-1:0]  set;
    logic              boundary;

    grp5_shift #(.W(PAIR_W)) i_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_bit),
        .win   (win)
    );

    grp5_lut i_lut (
        .code (win[CODE_W-1:0]),
        .dec  (dec)
    );

    grp5_flags #(.N(NFLAG)) i_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (stat_rd),
        .set   (set),
        .flags (stat_flags)
    );

    assign boundary = (q.cnt == CNT_W'(CODE_W - 1));

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        d.dv  = 1'b0;
        d.er  = 1'b0;
        d.rxd = '0;
        set   = '0;
        case (q.st)
            S_HUNT: begin
                if (win == {G_J, G_K}) begin
                    d.st     = S_FRAME;
                    d.cnt    = '0;
                    d.pend_t = 1'b0;
                    d.stb    = 1'b1;
                    d.dv     = 1'b1;
                    d.rxd    = N_PRE;
                end else if (win[PAIR_W-1:CODE_W] == G_J) begin
                    d.stb        = 1'b1;
                    d.er         = 1'b1;
                    set[F_SSD]   = 1'b1;
                end
            end
            default: begin
                d.cnt = boundary ? '0 : q.cnt + 1'b1;
                if (boundary) begin
                    if (q.pend_t) begin
                        d.pend_t = 1'b0;
                        d.st     = S_HUNT;
                        if (dec.kind != K_R) begin
                            d.stb      = 1'b1;
                            d.dv       = 1'b1;
                            d.er       = 1'b1;
                            set[F_ESD] = 1'b1;
                        end
                    end else begin
                        case (dec.kind)
                            K_DATA: begin
                                d.stb = 1'b1;
                                d.dv  = 1'b1;
                                d.rxd = dec.nib;
                            end
                            K_T: d.pend_t = 1'b1;
                            K_IDLE: begin
                                d.st       = S_HUNT;
                                d.stb      = 1'b1;
                                d.dv       = 1'b1;
                                d.er       = 1'b1;
                                set[F_ESD] = 1'b1;
                            end
                            default: begin
                                d.stb     = 1'b1;
                                d.dv      = 1'b1;
                                d.er      = 1'b1;
                                set[F_CW] = 1'b1;
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= S_HUNT;
            q.cnt    <= '0;
            q.pend_t <= 1'b0;
            q.stb    <= 1'b0;
            q.dv     <= 1'b0;
            q.er     <= 1'b0;
            q.rxd    <= '0;
        end else begin
            q <= d;
        end
    end

    assign rx_stb = q.stb;
    assign rx_dv  = q.dv;
    assign rx_er  = q.er;
    assign rxd    = q.rxd;

    // R5
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_stb |-> (!rx_dv && !rx_er && rxd == '0));

    // R5
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |=> !rx_stb);

    // R3
    preamble_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb && rx_dv && ($past(q.st) == S_HUNT)) |-> (rxd == N_PRE && !rx_er));

    // R9
    start_err_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb && !rx_dv) |-> (rx_er && rxd == '0 && stat_flags[F_SSD]));

    // R7
    error_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er |-> (rxd == '0));
endmodule

// File: tb/test_grp5_rx_decoder.sv
`timescale 1ns/1ps
module test_grp5_rx_decoder;
    localparam int MAXB = 4096;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_bit;
    logic       stat_rd;
    logic       rx_stb, rx_dv, rx_er;
    logic [3:0] rxd;
    logic [2:0] stat_flags;

    always #2.5 clk = ~clk;

    grp5_rx_decoder i_grp5_rx_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit     (rx_bit),
        .stat_rd    (stat_rd),
        .rx_stb     (rx_stb),
        .rx_dv      (rx_dv),
        .rx_er      (rx_er),
        .rxd        (rxd),
        .stat_flags (stat_flags)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic       bit_a [MAXB];
    logic       rd_a  [MAXB];
    logic       e_stb [MAXB];
    logic       e_dv  [MAXB];
    logic       e_er  [MAXB];
    logic [3:0] e_rxd [MAXB];
    logic [2:0] e_set [MAXB];
    string      e_tag [MAXB];
    int         nb;
    logic [2:0] st_model;

    function automatic logic [4:0] enc(input logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    function automatic bit is_data(input logic [4:0] c);
        for (int n = 0; n < 16; n++) if (enc(4'(n)) == c) return 1'b1;
        return 1'b0;
    endfunction

    // code groups that are neither data nor any control symbol
    function automatic bit is_unused(input logic [4:0] c);
        return !is_data(c) && c != 5'b11111 && c != 5'b11000 && c != 5'b10001
               && c != 5'b01101 && c != 5'b00111;
    endfunction

    function automatic logic [4:0] pick_bad();
        logic [4:0] c;
        case ($urandom % 4)
            0: return 5'b11000;
            1: return 5'b10001;
            2: return 5'b00111;
            default: begin
                c = 5'($urandom);
                while (!is_unused(c)) c = c + 5'd1;
                return c;
            end
        endcase
    endfunction

    task automatic clr();
        for (int i = 0; i < MAXB; i++) begin
            bit_a[i] = 1'b1; rd_a[i] = 1'b0; e_stb[i] = 1'b0; e_dv[i] = 1'b0;
            e_er[i] = 1'b0; e_rxd[i] = '0; e_set[i] = '0; e_tag[i] = "R5";
        end
        nb = 0;
    endtask

    task automatic put_ones(input int n);
        for (int i = 0; i < n; i++) begin bit_a[nb] = 1'b1; nb++; end
    endtask

    task automatic put_grp(input logic [4:0] c, input bit ev, input bit dv,
                           input bit er, input logic [3:0] nib,
                           input logic [2:0] set, input string tag);
        for (int b = 4; b >= 0; b--) begin bit_a[nb] = c[b]; nb++; end
        if (ev) begin
            e_stb[nb] = 1'b1; e_dv[nb] = dv; e_er[nb] = er;
            e_rxd[nb] = nib; e_set[nb] = set; e_tag[nb] = tag;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // drives the stored stream; assumes entry right after a falling edge
    task automatic run(input bit rd_at_end);
        put_ones(15);
        if (rd_at_end) rd_a[nb-3] = 1'b1;
        for (int i = 0; i < nb; i++) begin
            rx_bit  = bit_a[i];
            stat_rd = rd_a[i];
            @(posedge clk);
            @(negedge clk);
            st_model = (rd_a[i] ? 3'b000 : st_model) | e_set[i];
            chk({rx_stb, rx_dv, rx_er, rxd} == {e_stb[i], e_dv[i], e_er[i], e_rxd[i]},
                e_tag[i],
                $sformatf("stb%0b dv%0b er%0b rxd%h", rx_stb, rx_dv, rx_er, rxd),
                $sformatf("stb%0b dv%0b er%0b rxd%h", e_stb[i], e_dv[i], e_er[i], e_rxd[i]));
            chk(stat_flags == st_model, "R10",
                $sformatf("flags=%b", stat_flags), $sformatf("flags=%b", st_model));
        end
        stat_rd = 1'b0;
    endtask

    // R2 R3 R4 R6 R7 R8: one frame, endk 0=T/R, 1=T then data, 2=idle in frame
    task automatic frame(input int off, input int nnib, input bit allow_bad, input int endk);
        logic [3:0] n;
        put_ones(off);
        put_grp(5'b11111, 0, 0, 0, 0, 0, "R5");
        put_grp(5'b11000, 0, 0, 0, 0, 0, "R2");
        put_grp(5'b10001, 1, 1, 0, 4'b0101, 0, "R3");
        for (int k = 0; k < nnib; k++) begin
            if (allow_bad && ($urandom % 6) == 0)
                put_grp(pick_bad(), 1, 1, 1, 4'h0, 3'b100, "R7");
            else begin
                n = 4'($urandom);
                put_grp(enc(n), 1, 1, 0, n, 0, "R4");
            end
        end
        case (endk)
            0: begin
                put_grp(5'b01101, 0, 0, 0, 0, 0, "R6");
                put_grp(5'b00111, 0, 0, 0, 0, 0, "R6");
            end
            1: begin
                put_grp(5'b01101, 0, 0, 0, 0, 0, "R8");
                n = 4'($urandom);
                put_grp(enc(n), 1, 1, 1, 4'h0, 3'b010, "R8");
            end
            default: put_grp(5'b11111, 1, 1, 1, 4'h0, 3'b010, "R8");
        endcase
    endtask

    initial begin
        #(5.0 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        rst_n = 1'b0; rx_bit = 1'b1; stat_rd = 1'b0; st_model = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1
        chk({rx_stb, rx_dv, rx_er, rxd, stat_flags} == '0, "R1",
            $sformatf("%b%b%b %h %b", rx_stb, rx_dv, rx_er, rxd, stat_flags), "000 0 000");

        // R4: every data value in order, clean T/R end (R6)
        clr();
        put_ones(3);
        put_grp(5'b11000, 0, 0, 0, 0, 0, "R2");
        put_grp(5'b10001, 1, 1, 0, 4'b0101, 0, "R3");
        for (int k = 0; k < 16; k++) put_grp(enc(4'(k)), 1, 1, 0, 4'(k), 0, "R4");
        put_grp(5'b01101, 0, 0, 0, 0, 0, "R6");
        put_grp(5'b00111, 0, 0, 0, 0, 0, "R6");
        run(1'b0);

        // R9 with a read on the same edge (R10: set wins), then a plain read
        clr();
        put_grp(5'b11111, 0, 0, 0, 0, 0, "R5");
        put_grp(5'b11000, 0, 0, 0, 0, 0, "R9");
        put_grp(5'b11111, 1, 0, 1, 4'h0, 3'b001, "R9");
        rd_a[nb] = 1'b1;
        put_grp(5'b11111, 0, 0, 0, 0, 0, "R5");
        put_grp(5'b11111, 0, 0, 0, 0, 0, "R5");
        run(1'b1);

        // R7: each misplaced symbol and halt inside one frame
        clr();
        put_grp(5'b11000, 0, 0, 0, 0, 0, "R2");
        put_grp(5'b10001, 1, 1, 0, 4'b0101, 0, "R3");
        put_grp(5'b00100, 1, 1, 1, 4'h0, 3'b100, "R7");
        put_grp(5'b11000, 1, 1, 1, 4'h0, 3'b100, "R7");
        put_grp(5'b10001, 1, 1, 1, 4'h0, 3'b100, "R7");
        put_grp(5'b00111, 1, 1, 1, 4'h0, 3'b100, "R7");
        put_grp(5'b00000, 1, 1, 1, 4'h0, 3'b100, "R7");
        put_grp(enc(4'h9), 1, 1, 0, 4'h9, 0, "R4");
        put_grp(5'b01101, 0, 0, 0, 0, 0, "R6");
        put_grp(5'b00111, 0, 0, 0, 0, 0, "R6");
        run(1'b1);

        // R8: T then idle, T then data, bare idle; R2 at all five offsets
        clr();
        put_grp(5'b11000, 0, 0, 0, 0, 0, "R2");
        put_grp(5'b10001, 1, 1, 0, 4'b0101, 0, "R3");
        put_grp(5'b01101, 0, 0, 0, 0, 0, "R8");
        put_grp(5'b11111, 1, 1, 1, 4'h0, 3'b010, "R8");
        run(1'b1);
        for (int off = 0; off < 5; off++) begin
            clr();
            frame(off, 2, 1'b0, off % 3);
            run(off == 4);
        end

        // random frames
        for (int f = 0; f < 80; f++) begin
            clr();
            frame($urandom % 5, 1 + $urandom % 20, 1'b1, $urandom % 3);
            run(($urandom % 3) == 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule